// File: doc/BRIEF.md
# UART Multiprocessor Address Recognizer

This block sits behind the framing logic of a 9-bit serial receiver and decides which received bytes reach the host. Each received byte comes with a ninth bit. A set ninth bit marks an address frame, and a clear ninth bit marks a data frame. When multiprocessor filtering is enabled, each address frame is compared against two programmable registers:

- a slave address;
- an enable mask that picks which address bits must agree.

From the same two registers the block also derives a broadcast address. It is their bitwise OR, and zero bits in the result count as don't-care.

A matching address frame is passed on as a one-cycle accept pulse and selects this node. While the node is selected, data frames pass through. A later address frame that does not match drops the selection, and data frames are then discarded. After reset both registers hold zero, so every address matches and filtering is in effect off. When the enable input is low, every received byte is accepted.

The control is a three-state machine:

- `ST_PASS`: filtering is off.
- `ST_HUNT`: filtering is on and the node is not selected.
- `ST_SELECTED`: filtering is on and the node has been addressed.

The transitions are as follows:

- Any state goes to `ST_PASS` whenever the enable input is low.
- `ST_PASS` goes to `ST_HUNT` when the enable input is high, or to `ST_SELECTED` if a matching address frame arrives in that same cycle.
- `ST_HUNT` goes to `ST_SELECTED` on a matching address frame, and otherwise holds.
- `ST_SELECTED` goes back to `ST_HUNT` on a non-matching address frame, and otherwise holds.

Top module: `mpc_addr_filter`

## Requirements
- R1: After reset the slave address and mask registers are zero, `acc_valid` and `addressed` are low, and with these values every address frame is accepted.
- R2: While `mp_en` is low, every byte strobed by `rx_valid` is accepted whatever its ninth bit, with `acc_data` equal to that byte, and `addressed` is low from the following cycle.
- R3: With `mp_en` high, an address frame is accepted when `((rx_byte ^ ADDR) & MASK) == 0`, where a mask bit of 1 means that bit must match.
- R4: With `mp_en` high, an address frame is also accepted when `rx_byte` has a 1 in every bit position where `ADDR | MASK` is 1. Other positions are don't-care, so 0xFF always qualifies.
- R5: The accept pulse `acc_valid` is high for exactly the one cycle after the `rx_valid` strobe. It carries the byte on `acc_data` and the ninth bit on `acc_is_addr`.
- R6: An accepted address frame sets `addressed` in the same cycle as its accept pulse. While `addressed` is high, data frames (ninth bit 0) are accepted.
- R7: With `mp_en` high, an address frame that matches neither the given nor the broadcast address gives no accept pulse and clears `addressed`. Data frames are then dropped until a match.
- R8: Register writes through `cfg_addr_we` and `cfg_mask_we` take effect from the next cycle. A frame strobed in the same cycle as a write is judged against the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_addr_we | input | 1 | Write strobe for the slave address register |
| cfg_mask_we | input | 1 | Write strobe for the enable mask register |
| cfg_wdata | input | DATA_W | Write data for either register |
| mp_en | input | 1 | Multiprocessor filtering enable |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_bit9 | input | 1 | Ninth bit of the received frame (1 = address frame) |
| rx_byte | input | DATA_W | Received byte |
| acc_valid | output | 1 | Accept pulse, one cycle after the strobe |
| acc_data | output | DATA_W | Accepted byte |
| acc_is_addr | output | 1 | Ninth bit of the accepted frame |
| addressed | output | 1 | Node is currently selected |

## Verification
The register write port and the match decision can act in the same cycle. This happens when software rewrites the slave address or mask while an address frame is arriving. The bench provokes it by raising `cfg_addr_we` in the very cycle it strobes an address frame whose byte equals the new address but not the old one. That frame must be rejected. An identical frame one cycle later must be accepted. The selection-state update and the accept decision also coincide on every address frame, so every sweep step checks `addressed` together with the pulse.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [1:0] {
        ST_PASS     = 2'd0,
        ST_HUNT     = 2'd1,
        ST_SELECTED = 2'd2
    } mpc_state_e;

endpackage

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] slv_addr,
    output logic [DATA_W-1:0] slv_mask
);

    // Both registers come out of reset as zero: every bit is then don't-care.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slv_addr <= '0;
            slv_mask <= '0;
        end else begin
            if (addr_we) slv_addr <= wdata;
            if (mask_we) slv_mask <= wdata;
        end
    end

endmodule

// File: rtl/mpc_match.sv
module mpc_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cand,
    input  logic [DATA_W-1:0] slv_addr,
    input  logic [DATA_W-1:0] slv_mask,
    output logic              given_hit,
    output logic              bcast_hit
);

    logic [DATA_W-1:0] given_ok;
    logic [DATA_W-1:0] bcast_ok;

    // One comparator slice per bit position.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic bcast_bit;
        // The broadcast pattern for this bit: 1 means the byte must carry a 1 here.
        assign bcast_bit   = slv_addr[i] | slv_mask[i];
        // Given address: a bit with mask 0 is ignored.
        assign given_ok[i] = ~slv_mask[i] | ~(cand[i] ^ slv_addr[i]);
        assign bcast_ok[i] = ~bcast_bit | cand[i];
    end

    assign given_hit = &given_ok;
    assign bcast_hit = &bcast_ok;

endmodule

// File: rtl/mpc_fsm.sv
module mpc_fsm
    import mpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mp_en,
    input  logic              rx_valid,
    input  logic              rx_bit9,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              addr_hit,
    output logic              acc_valid,
    output logic [DATA_W-1:0] acc_data,
    output logic              acc_is_addr,
    output logic              addressed
);

    mpc_state_e state_q, state_d;
    logic       addr_frame;
    logic       accept_d;

    assign addr_frame = rx_valid & rx_bit9;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!mp_en) begin
            state_d = ST_PASS;
        end else begin
            unique case (state_q)
                ST_PASS: begin
                    state_d = (addr_frame && addr_hit) ? ST_SELECTED : ST_HUNT;
                end
                ST_HUNT: begin
                    if (addr_frame && addr_hit) state_d = ST_SELECTED;
                end
                ST_SELECTED: begin
                    if (addr_frame && !addr_hit) state_d = ST_HUNT;
                end
                default: state_d = ST_PASS;
            endcase
        end
    end

    // Accept decision: filter off, address match, or selected data frame.
    always_comb begin
        accept_d = 1'b0;
        if (rx_valid) begin
            if (!mp_en)       accept_d = 1'b1;
            else if (rx_bit9) accept_d = addr_hit;
            else              accept_d = (state_q == ST_SELECTED);
        end
    end

    // Output registers: the pulse trails the strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid   <= 1'b0;
            acc_data    <= '0;
            acc_is_addr <= 1'b0;
        end else begin
            acc_valid <= accept_d;
            if (accept_d) begin
                acc_data    <= rx_byte;
                acc_is_addr <= rx_bit9;
            end
        end
    end

    assign addressed = (state_q == ST_SELECTED);

endmodule

// File: rtl/mpc_addr_filter.sv
module mpc_addr_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_addr_we,
    input  logic              cfg_mask_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mp_en,
    input  logic              rx_valid,
    input  logic              rx_bit9,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              acc_valid,
    output logic [DATA_W-1:0] acc_data,
    output logic              acc_is_addr,
    output logic              addressed
);

    logic [DATA_W-1:0] slv_addr;
    logic [DATA_W-1:0] slv_mask;
    logic              given_hit;
    logic              bcast_hit;
    logic              addr_hit;

    mpc_cfg_regs #(.DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_we  (cfg_addr_we),
        .mask_we  (cfg_mask_we),
        .wdata    (cfg_wdata),
        .slv_addr (slv_addr),
        .slv_mask (slv_mask)
    );

    mpc_match #(.DATA_W(DATA_W)) match_i (
        .cand      (rx_byte),
        .slv_addr  (slv_addr),
        .slv_mask  (slv_mask),
        .given_hit (given_hit),
        .bcast_hit (bcast_hit)
    );

    assign addr_hit = given_hit | bcast_hit;

    mpc_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mp_en       (mp_en),
        .rx_valid    (rx_valid),
        .rx_bit9     (rx_bit9),
        .rx_byte     (rx_byte),
        .addr_hit    (addr_hit),
        .acc_valid   (acc_valid),
        .acc_data    (acc_data),
        .acc_is_addr (acc_is_addr),
        .addressed   (addressed)
    );

endmodule

// File: rtl/mpc_addr_filter_chk.sv
module mpc_addr_filter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mp_en,
    input logic              rx_valid,
    input logic              rx_bit9,
    input logic [DATA_W-1:0] rx_byte,
    input logic              acc_valid,
    input logic [DATA_W-1:0] acc_data,
    input logic              acc_is_addr,
    input logic              addressed
);

    p_pass_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !mp_en |=> acc_valid && acc_data == $past(rx_byte));

    p_pass_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mp_en |=> !addressed);

    p_pulse_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !acc_valid);

    p_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && mp_en |=> !acc_valid || acc_is_addr == $past(rx_bit9));

    p_addr_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && mp_en && rx_bit9 |=> acc_valid == addressed);

    p_sel_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && mp_en && !rx_bit9 && addressed |=> acc_valid && addressed);

    p_hunt_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && mp_en && !rx_bit9 && !addressed |=> !acc_valid && !addressed);

endmodule

bind mpc_addr_filter mpc_addr_filter_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mp_en       (mp_en),
    .rx_valid    (rx_valid),
    .rx_bit9     (rx_bit9),
    .rx_byte     (rx_byte),
    .acc_valid   (acc_valid),
    .acc_data    (acc_data),
    .acc_is_addr (acc_is_addr),
    .addressed   (addressed)
);

// File: tb/mpc_addr_filter_tb_top.sv
module mpc_addr_filter_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_addr_we = 1'b0;
    logic         cfg_mask_we = 1'b0;
    logic [W-1:0] cfg_wdata = '0;
    logic         mp_en = 1'b0;
    logic         rx_valid = 1'b0;
    logic         rx_bit9 = 1'b0;
    logic [W-1:0] rx_byte = '0;
    logic         acc_valid;
    logic [W-1:0] acc_data;
    logic         acc_is_addr;
    logic         addressed;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mpc_addr_filter #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_addr_we(cfg_addr_we), .cfg_mask_we(cfg_mask_we),
        .cfg_wdata(cfg_wdata), .mp_en(mp_en), .rx_valid(rx_valid), .rx_bit9(rx_bit9),
        .rx_byte(rx_byte), .acc_valid(acc_valid), .acc_data(acc_data),
        .acc_is_addr(acc_is_addr), .addressed(addressed)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model_hit(input logic [W-1:0] b, input logic [W-1:0] a,
                                     input logic [W-1:0] m);
        int bc;
        bc = int'(a) | int'(m);
        return ((int'(b) ^ int'(a)) & int'(m)) == 0 || (int'(b) & bc) == bc;
    endfunction

    task automatic write_cfg(input logic [W-1:0] a, input logic [W-1:0] m);
        @(negedge clk);
        cfg_addr_we = 1'b1; cfg_wdata = a;
        @(negedge clk);
        cfg_addr_we = 1'b0; cfg_mask_we = 1'b1; cfg_wdata = m;
        @(negedge clk);
        cfg_mask_we = 1'b0;
    endtask

    // Drives one strobe at a falling edge; outputs are read at the next falling edge.
    task automatic send(input logic b9, input logic [W-1:0] b);
        rx_valid = 1'b1; rx_bit9 = b9; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic sweep(input logic [W-1:0] a, input logic [W-1:0] m);
        for (int b = 0; b < 256; b++) begin
            bit hit;
            hit = model_hit(W'(b), a, m);
            send(1'b1, W'(b));
            chk("R3/R4 addr accept", int'(acc_valid), int'(hit));
            chk("R6/R7 addressed", int'(addressed), int'(hit));
            if (hit) begin
                chk("R5 data", int'(acc_data), b);
                chk("R5 tag", int'(acc_is_addr), 1);
            end
            send(1'b0, ~W'(b));
            chk("R6/R7 data frame", int'(acc_valid), int'(hit));
            if (hit) chk("R5 tag data", int'(acc_is_addr), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset acc_valid", int'(acc_valid), 0);
        chk("R1 reset addressed", int'(addressed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle no pulse", int'(acc_valid), 0);

        // R2: filtering off, every byte accepted
        for (int b = 0; b < 256; b++) begin
            send(b[0], W'(b));
            chk("R2 pass accept", int'(acc_valid), 1);
            chk("R2 pass data", int'(acc_data), b);
            chk("R2 pass addressed", int'(addressed), 0);
        end
        @(negedge clk);
        chk("R5 single pulse", int'(acc_valid), 0);

        mp_en = 1'b1;
        @(negedge clk);
        // R1: reset register values accept every address frame
        sweep(8'h00, 8'h00);

        write_cfg(8'hC0, 8'hF9); sweep(8'hC0, 8'hF9);
        write_cfg(8'hE0, 8'hFA); sweep(8'hE0, 8'hFA);
        write_cfg(8'hC0, 8'hFC); sweep(8'hC0, 8'hFC);
        write_cfg(8'h5A, 8'hFF); sweep(8'h5A, 8'hFF);
        write_cfg(8'h21, 8'h0F); sweep(8'h21, 8'h0F);

        // R7: mismatch drops selection, following data dropped
        write_cfg(8'h12, 8'hFF);
        send(1'b1, 8'h12);
        chk("R6 select", int'(addressed), 1);
        send(1'b1, 8'h13);
        chk("R7 mismatch no pulse", int'(acc_valid), 0);
        chk("R7 mismatch clears", int'(addressed), 0);
        send(1'b0, 8'h55);
        chk("R7 data dropped", int'(acc_valid), 0);
        send(1'b1, 8'hFF);
        chk("R4 broadcast FF", int'(acc_valid), 1);

        // R8: write and address frame in the same cycle
        send(1'b1, 8'h13);
        chk("R8 pre state", int'(addressed), 0);
        cfg_addr_we = 1'b1; cfg_wdata = 8'h34;
        send(1'b1, 8'h34);
        cfg_addr_we = 1'b0;
        chk("R8 old value judged", int'(acc_valid), 0);
        send(1'b1, 8'h34);
        chk("R8 new value used", int'(acc_valid), 1);
        chk("R8 selected", int'(addressed), 1);

        // R2: dropping enable clears selection
        mp_en = 1'b0;
        @(negedge clk);
        chk("R2 disable clears", int'(addressed), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule